// File: doc/BRIEF.md
# Monochrome Framebuffer with Pixel Scan Port

This block holds the picture for a black-and-white display of 256 rows by 512 columns. The image lives in 8192 words of 16 bits. A processor reaches it as an ordinary word memory. Its read is combinational, and a write is accepted on the clock edge when the write enable is high.

A second port is read-only. A display driver uses it to fetch one pixel at a time. The pixel position comes from the row and column inputs, or from a built-in raster counter. That counter walks every pixel of the frame in display order and flags the first pixel of each frame.

Storage layout:
- Each word holds 16 neighbouring pixels of one row.
- Each row takes 32 consecutive words, and the first row starts at word 0.
- Within a word, the leftmost of its 16 pixels is the least significant bit.
- A set bit is shown as black.

Top module: `mono_framebuffer`

## Requirements
- R1: `cpu_rdata` equals the word stored at `cpu_addr` in the same cycle, with no clock edge in between.
- R2: When `cpu_we` is 1 at a rising edge, `cpu_wdata` is stored at `cpu_addr` and is visible from the next cycle. When `cpu_we` is 0, no word changes.
- R3: With `pix_use_scan` = 0, `pix_bit` is bit (col mod 16) of word (row*32 + col/16), counting from bit 0 = LSB. Row is 0..255 from the top and col is 0..511 from the left.
- R4: `pix_bit` = 1 means a black pixel and 0 means a white pixel. It is the stored bit itself, not inverted.
- R5: When a processor write and a pixel read hit the same word in one cycle, `pix_bit` and `cpu_rdata` in that cycle give the old contents. The new value appears from the next cycle.
- R6: After `rst` (synchronous, active high), the raster position is row 0, column 0. Each edge with `scan_en` = 1 adds one to the column. From column 511 it goes to column 0 of the next row. From row 255, column 511 it goes to row 0, column 0.
- R7: `scan_frame_start` is 1 exactly when the raster position is row 0, column 0.
- R8: While `scan_en` is 0, the raster position holds its value.
- R9: With `pix_use_scan` = 1, `pix_bit` uses the raster position in place of `pix_row`/`pix_col`, with the same mapping as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the raster counter |
| cpu_addr | input | 13 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_rdata | output | 16 | Word at `cpu_addr`, combinational |
| pix_use_scan | input | 1 | 1: pixel port uses the raster position |
| pix_row | input | 8 | Pixel row when not scanning |
| pix_col | input | 9 | Pixel column when not scanning |
| scan_en | input | 1 | Advance the raster counter |
| scan_row | output | 8 | Current raster row |
| scan_col | output | 9 | Current raster column |
| scan_frame_start | output | 1 | Raster position is (0,0) |
| pix_bit | output | 1 | Selected pixel, 1 = black |

## Verification
A processor write and a pixel fetch can touch the same word in one cycle. The bench provokes this by writing the inverse of a word while the pixel port points into that word. It expects both `pix_bit` and `cpu_rdata` to show the old contents in that cycle and the new contents in the next one. The raster scan and processor writes can also coincide. During the full-frame scan, the behavioural model is compared every cycle, so the wrap from the last pixel to the frame-start flag is judged against the same memory image.

// File: rtl/fb_pkg.sv
package fb_pkg;
    parameter int ROW_W  = 8;
    parameter int COL_W  = 9;
    parameter int DATA_W = 16;

    localparam int BIT_W     = $clog2(DATA_W);
    localparam int WCOL_W    = COL_W - BIT_W;
    localparam int ADDR_W    = ROW_W + WCOL_W;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int ROW_LAST  = (1 << ROW_W) - 1;
    localparam int COL_LAST  = (1 << COL_W) - 1;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } pix_pos_t;

    function automatic logic [ADDR_W-1:0] word_of(input pix_pos_t p);
        return {p.row, p.col[COL_W-1:BIT_W]};
    endfunction

    function automatic logic [BIT_W-1:0] lane_of(input pix_pos_t p);
        return p.col[BIT_W-1:0];
    endfunction
endpackage

// File: rtl/fb_word_store.sv
module fb_word_store
    import fb_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] addr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int N = 1 << AW;

    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr_a] <= wdata;
        end
    end

    assign rdata_a = mem[addr_a];
    assign rdata_b = mem[addr_b];
endmodule

// File: rtl/fb_raster_counter.sv
module fb_raster_counter
    import fb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    output pix_pos_t pos,
    output logic     first
);
    pix_pos_t pos_q;
    pix_pos_t pos_d;
    logic     col_end;

    assign col_end = (pos_q.col == COL_W'(COL_LAST));

    always_comb begin
        pos_d = pos_q;
        if (en) begin
            pos_d.col = pos_q.col + 1'b1;
            if (col_end) begin
                pos_d.row = pos_q.row + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos   = pos_q;
    assign first = (pos_q.row == '0) && (pos_q.col == '0);
endmodule

// File: rtl/fb_pixel_fetch.sv
module fb_pixel_fetch
    import fb_pkg::*;
(
    input  logic              use_scan,
    input  pix_pos_t          ext_pos,
    input  pix_pos_t          scan_pos,
    output logic [ADDR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] word_data,
    output logic              pixel
);
    pix_pos_t                 sel_pos;
    logic [BIT_W-1:0]         lane;

    assign sel_pos   = use_scan ? scan_pos : ext_pos;
    assign word_addr = word_of(sel_pos);
    assign lane      = lane_of(sel_pos);
    assign pixel     = word_data[lane];
endmodule

// File: rtl/mono_framebuffer.sv
module mono_framebuffer
    import fb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              pix_use_scan,
    input  logic [ROW_W-1:0]  pix_row,
    input  logic [COL_W-1:0]  pix_col,
    input  logic              scan_en,
    output logic [ROW_W-1:0]  scan_row,
    output logic [COL_W-1:0]  scan_col,
    output logic              scan_frame_start,
    output logic              pix_bit
);
    pix_pos_t          ext_pos;
    pix_pos_t          ras_pos;
    logic [ADDR_W-1:0] pix_addr;
    logic [DATA_W-1:0] pix_word;

    assign ext_pos.row = pix_row;
    assign ext_pos.col = pix_col;

    fb_word_store #(.AW(ADDR_W), .DW(DATA_W)) store_i (
        .clk     (clk),
        .we      (cpu_we),
        .addr_a  (cpu_addr),
        .wdata   (cpu_wdata),
        .rdata_a (cpu_rdata),
        .addr_b  (pix_addr),
        .rdata_b (pix_word)
    );

    fb_raster_counter raster_i (
        .clk   (clk),
        .rst   (rst),
        .en    (scan_en),
        .pos   (ras_pos),
        .first (scan_frame_start)
    );

    fb_pixel_fetch fetch_i (
        .use_scan  (pix_use_scan),
        .ext_pos   (ext_pos),
        .scan_pos  (ras_pos),
        .word_addr (pix_addr),
        .word_data (pix_word),
        .pixel     (pix_bit)
    );

    assign scan_row = ras_pos.row;
    assign scan_col = ras_pos.col;
endmodule

// File: rtl/fb_checker.sv
module fb_checker
    import fb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_we,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              pix_use_scan,
    input logic [ROW_W-1:0]  pix_row,
    input logic [COL_W-1:0]  pix_col,
    input logic              scan_en,
    input logic [ROW_W-1:0]  scan_row,
    input logic [COL_W-1:0]  scan_col,
    input logic              scan_frame_start,
    input logic              pix_bit
);
    // R2: a write is visible on the read port in the next cycle
    assert_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_we |=> (cpu_addr != $past(cpu_addr)) || (cpu_rdata == $past(cpu_wdata)));

    // R3: pixel port and processor port agree on a shared word
    assert_pixel_matches_word_R3: assert property (@(posedge clk) disable iff (rst)
        (!pix_use_scan && ({pix_row, pix_col[COL_W-1:BIT_W]} == cpu_addr))
            |-> (pix_bit == cpu_rdata[pix_col[BIT_W-1:0]]));

    // R6: column step inside a row
    assert_col_step_R6: assert property (@(posedge clk) disable iff (rst)
        (scan_en && scan_col != COL_W'(COL_LAST))
            |=> (scan_col == $past(scan_col) + 1'b1) && $stable(scan_row));

    // R6: end of row moves to the next row
    assert_row_step_R6: assert property (@(posedge clk) disable iff (rst)
        (scan_en && scan_col == COL_W'(COL_LAST))
            |=> (scan_col == '0) && (scan_row == $past(scan_row) + 1'b1));

    // R7: last pixel of the frame leads to the frame-start flag
    assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (scan_en && scan_col == COL_W'(COL_LAST) && scan_row == ROW_W'(ROW_LAST))
            |=> scan_frame_start);

    // R8: counter holds while not enabled
    assert_scan_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(scan_row) && $stable(scan_col));
endmodule

bind mono_framebuffer fb_checker chk_i (
    .clk              (clk),
    .rst              (rst),
    .cpu_addr         (cpu_addr),
    .cpu_wdata        (cpu_wdata),
    .cpu_we           (cpu_we),
    .cpu_rdata        (cpu_rdata),
    .pix_use_scan     (pix_use_scan),
    .pix_row          (pix_row),
    .pix_col          (pix_col),
    .scan_en          (scan_en),
    .scan_row         (scan_row),
    .scan_col         (scan_col),
    .scan_frame_start (scan_frame_start),
    .pix_bit          (pix_bit)
);

// File: tb/mono_framebuffer_tb_top.sv
module mono_framebuffer_tb_top;
    logic        clk;
    logic        rst;
    logic [12:0] cpu_addr;
    logic [15:0] cpu_wdata;
    logic        cpu_we;
    logic [15:0] cpu_rdata;
    logic        pix_use_scan;
    logic [7:0]  pix_row;
    logic [8:0]  pix_col;
    logic        scan_en;
    logic [7:0]  scan_row;
    logic [8:0]  scan_col;
    logic        scan_frame_start;
    logic        pix_bit;

    int checks = 0;
    int errors = 0;

    // behavioural reference
    logic [15:0] ref_mem [8192];
    bit          ref_ok  [8192];
    int          m_row = 0;
    int          m_col = 0;
    bit          prev_en = 1'b1;
    bit          prev_we = 1'b0;
    int          prev_addr = 0;

    mono_framebuffer dut_i (
        .clk (clk), .rst (rst),
        .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_we (cpu_we),
        .cpu_rdata (cpu_rdata),
        .pix_use_scan (pix_use_scan), .pix_row (pix_row), .pix_col (pix_col),
        .scan_en (scan_en), .scan_row (scan_row), .scan_col (scan_col),
        .scan_frame_start (scan_frame_start), .pix_bit (pix_bit)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [15:0] pat(input int i);
        int v;
        v = (i * 40503 + 7) ^ (i >> 3) ^ (i << 9);
        return v[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // called just after a falling edge
    task automatic step(input bit we, input int a, input logic [15:0] d,
                        input bit use_scan, input int r, input int c, input bit en);
        int er, ec, idx;
        logic exp_bit;
        cpu_we = we; cpu_addr = a[12:0]; cpu_wdata = d;
        pix_use_scan = use_scan; pix_row = r[7:0]; pix_col = c[8:0]; scan_en = en;
        #1;
        // R6 / R8: raster position against model
        if (prev_en) begin
            check(scan_row == m_row[7:0] && scan_col == m_col[8:0], "R6",
                  {scan_row, scan_col}, m_row * 512 + m_col);
        end else begin
            check(scan_row == m_row[7:0] && scan_col == m_col[8:0], "R8",
                  {scan_row, scan_col}, m_row * 512 + m_col);
        end
        check(scan_frame_start == (m_row == 0 && m_col == 0), "R7",
              scan_frame_start, (m_row == 0 && m_col == 0));
        if (!rst) begin
            if (ref_ok[a]) begin
                if (prev_we && prev_addr == a)
                    check(cpu_rdata == ref_mem[a], "R2", cpu_rdata, ref_mem[a]);
                else if (we)
                    check(cpu_rdata == ref_mem[a], "R5", cpu_rdata, ref_mem[a]);
                else
                    check(cpu_rdata == ref_mem[a], "R1", cpu_rdata, ref_mem[a]);
            end
            er = use_scan ? m_row : r;
            ec = use_scan ? m_col : c;
            idx = er * 32 + ec / 16;
            if (ref_ok[idx]) begin
                exp_bit = ref_mem[idx][ec % 16];
                if (we && idx == a)
                    check(pix_bit == exp_bit, "R5", pix_bit, exp_bit);
                else if (use_scan)
                    check(pix_bit == exp_bit, "R9", pix_bit, exp_bit);
                else if (exp_bit)
                    check(pix_bit == exp_bit, "R4", pix_bit, exp_bit);
                else
                    check(pix_bit == exp_bit, "R3", pix_bit, exp_bit);
            end
        end
        @(posedge clk);
        if (we) begin
            ref_mem[a] = d;
            ref_ok[a] = 1'b1;
        end
        if (rst) begin
            m_row = 0; m_col = 0;
        end else if (en) begin
            if (m_col == 511) begin
                m_col = 0;
                m_row = (m_row + 1) % 256;
            end else begin
                m_col = m_col + 1;
            end
        end
        prev_en = en || rst;
        prev_we = we;
        prev_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        pix_use_scan = 0; pix_row = 0; pix_col = 0; scan_en = 0;
        @(negedge clk);
        // reset state (R6, R7)
        for (int i = 0; i < 3; i++) step(0, 0, 16'h0, 0, 0, 0, 1);
        rst = 1'b0;
        // fill the whole image
        for (int i = 0; i < 8192; i++) step(1, i, pat(i), 0, 0, 0, 0);
        // processor reads (R1) and immediate readback after write (R2)
        step(0, 0, 16'h0, 0, 0, 0, 0);
        step(0, 8191, 16'h0, 0, 255, 511, 0);
        step(1, 100, 16'hA5C3, 0, 3, 64, 0);
        step(0, 100, 16'h0, 0, 3, 64, 0);
        // write disabled leaves contents unchanged (R2)
        step(0, 101, 16'hFFFF, 0, 0, 0, 0);
        step(0, 101, 16'h0, 0, 0, 0, 0);
        // pixel corners and scattered positions (R3, R4)
        step(0, 5, 16'h0, 0, 0, 0, 0);
        step(0, 5, 16'h0, 0, 0, 511, 0);
        step(0, 5, 16'h0, 0, 255, 0, 0);
        step(0, 5, 16'h0, 0, 255, 511, 0);
        step(1, 0, 16'h8001, 0, 0, 0, 0);
        for (int c = 0; c < 16; c++) step(0, 1, 16'h0, 0, 0, c, 0);
        for (int k = 0; k < 64; k++) step(0, k * 97 % 8192, 16'h0, 0, (k * 37) % 256, (k * 53) % 512, 0);
        // same-cycle write and pixel read of one word (R5)
        step(1, 10 * 32 + 2, ~ref_mem[10 * 32 + 2], 0, 10, 37, 0);
        step(0, 10 * 32 + 2, 16'h0, 0, 10, 37, 0);
        step(1, 8191, ~ref_mem[8191], 0, 255, 500, 0);
        step(0, 8191, 16'h0, 0, 255, 500, 0);
        // hold the counter (R8)
        for (int i = 0; i < 4; i++) step(0, 0, 16'h0, 1, 0, 0, 0);
        // full frame scan plus a little (R6, R7, R9), with an occasional write
        for (int i = 0; i < 131072 + 600; i++) begin
            if (i % 4099 == 7)
                step(1, (i * 13) % 8192, pat(i + 3), 1, 0, 0, 1);
            else
                step(0, (i * 7) % 8192, 16'h0, 1, 0, 0, 1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule